// File: doc/BRIEF.md
# Sleep-Mode Interrupt Capture and Replay

This block sits beside a bank of external interrupt lines and keeps a record of their activity while the main interrupt controller is asleep. Each line passes through a two-flop synchronizer and a detector that can be set per line to level or edge operation and to high/rising or low/falling polarity. Any detected event sets a sticky status bit. This happens whether or not the block is enabled, so events that arrive while the system powers down are not lost.

On wake-up, software issues a flush command. The block then walks the lines in ascending order, one line per cycle. For every recorded line that is not masked, it drives a one-cycle pulse of that line's configured polarity toward the parent controller and clears the line's status bit. Software drives the block through a simple word-addressed register bus. Each configuration field has a pair of registers, one that sets bits and one that clears bits, where writing a 1 acts and writing a 0 does nothing. The status register has a matching acknowledge register.

Top module: `sleep_irq_capture`

## Requirements
- R1: After reset the status, mask and control values read 0. Every sense bit reads 0 (edge) and every polarity bit reads 1 (rising/high). Every `replay_out` bit is 0, which is the inactive level for polarity 1.
- R2: Line n sits at bit (n mod 32) of the word at byte offset (n/32)*4 above each group base. The group bases are: status 0x000, acknowledge 0x040, mask-set 0x0C0, mask-clear 0x100, sense-set 0x180, sense-clear 0x1C0, polarity-set 0x240, polarity-clear 0x280 and control 0x300.
- R3: Writing 1 to a bit of a set register sets that line's mask, sense or polarity bit, and writing 1 to a bit of the matching clear register clears it. Writing 0 bits has no effect. A read at either address of a pair returns the current value.
- R4: With sense 0 (edge), a line records a rising edge when polarity is 1 and a falling edge when polarity is 0. The opposite edge records nothing.
- R5: With sense 1 (level), a line records in every cycle its synchronized input equals its polarity bit. An acknowledge therefore does not stick while the line is still active.
- R6: Events are recorded into status even when the enable bit (control bit 0) is 0.
- R7: Writing 1 to a bit of the acknowledge group clears that line's status bit. A new event in the same cycle wins over the acknowledge.
- R8: While edge-only mode (control bit 1) is 1, lines with sense 1 record nothing, and edge lines record as usual.
- R9: A control write that sets flush (bit 2) together with enable (bit 0) starts a scan. If the write is sampled at clock edge E, line i is examined at edge E+1+i. A recorded line then shows its pulse on `replay_out[i]` during the cycle that follows, and its status bit is cleared. Lines are replayed one at a time.
- R10: A flush write whose enable bit is 0 starts no scan. Status is unchanged, no pulse appears, and control reads 0.
- R11: Masked lines keep recording status but are not replayed, and their status survives the flush.
- R12: Each `replay_out[i]` rests at the inverse of its polarity bit and pulses to the polarity bit's value.
- R13: Control reads {flush-in-progress, edge-only, enable} in bits 2..0. Bit 2 reads 1 during a scan and 0 afterwards. A flush written during a scan is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_wr_en | input | 1 | Register write strobe |
| bus_rd_en | input | 1 | Register read strobe; data is valid on the cycle after the strobe |
| bus_addr | input | ADDR_W (12) | Byte address; bits 1..0 are ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_in | input | NUM_LINES (40) | Asynchronous external interrupt lines |
| replay_out | output | NUM_LINES (40) | Replay lines toward the parent controller |

## Verification
Some rules are checked by assertions on every cycle. A scan never pulses more than one line at a time. No pulse appears for a line that was masked in the cycle before. A pulse only follows a cycle in which a scan was running. In edge-only mode, no level line gains a status bit. An acknowledge with no coincident event clears its bits. Other behaviour can only be shown by the bench's scenarios: the exact cycle at which each line's pulse appears, its level and the resting level, the detector behaviour for each sense and polarity, flush being refused while disabled, and the register map itself.

// File: rtl/sic_pkg.sv
package sic_pkg;

  localparam int GRP_W  = 6;
  localparam int DATA_W = 32;

  // 64-byte register groups, decoded from the upper address bits
  typedef enum logic [GRP_W-1:0] {
    GRP_STATUS = 6'd0,
    GRP_ACK    = 6'd1,
    GRP_MSET   = 6'd3,
    GRP_MCLR   = 6'd4,
    GRP_SSET   = 6'd6,
    GRP_SCLR   = 6'd7,
    GRP_PSET   = 6'd9,
    GRP_PCLR   = 6'd10,
    GRP_CTRL   = 6'd12
  } grp_e;

  localparam int CTRL_EN        = 0;
  localparam int CTRL_EDGE_ONLY = 1;
  localparam int CTRL_FLUSH     = 2;

endpackage

// File: rtl/sic_line_detect.sv
module sic_line_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic irq_raw,
  input  logic pol,
  input  logic level,
  output logic event_o
);

  logic meta_q, sync_q, prev_q;
  logic meta_d, sync_d, prev_d;

  always_comb begin
    meta_d = irq_raw;
    sync_d = meta_q;
    prev_d = sync_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      meta_q <= meta_d;
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  logic rise, fall;
  assign rise = sync_q & ~prev_q;
  assign fall = ~sync_q & prev_q;

  always_comb begin
    if (level) event_o = (sync_q == pol);
    else       event_o = pol ? rise : fall;
  end

endmodule

// File: rtl/sic_regs.sv
module sic_regs
  import sic_pkg::*;
#(
  parameter int NUM_LINES = 40,
  parameter int ADDR_W    = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic                 rd_en,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [DATA_W-1:0]    wdata,
  output logic [DATA_W-1:0]    rdata,
  input  logic [NUM_LINES-1:0] event_vec,
  input  logic [NUM_LINES-1:0] replay_clr,
  input  logic                 busy,
  output logic [NUM_LINES-1:0] mask_o,
  output logic [NUM_LINES-1:0] sense_o,
  output logic [NUM_LINES-1:0] pol_o,
  output logic [NUM_LINES-1:0] status_o,
  output logic                 flush_start_o
);

  localparam int NWORDS = (NUM_LINES + DATA_W - 1) / DATA_W;
  localparam int WORD_W = ADDR_W - GRP_W - 2;
  localparam int PADW   = NWORDS * DATA_W;

  logic [GRP_W-1:0]  grp;
  logic [WORD_W-1:0] word;
  logic              unused_lsb;

  assign grp        = addr[ADDR_W-1 -: GRP_W];
  assign word       = addr[2 +: WORD_W];
  assign unused_lsb = ^addr[1:0];

  // per-line write-one decode
  logic [NUM_LINES-1:0] wbit;
  for (genvar n = 0; n < NUM_LINES; n++) begin : g_wbit
    assign wbit[n] = (word == WORD_W'(n / DATA_W)) && wdata[n % DATA_W];
  end

  logic wr_ack, wr_mset, wr_mclr, wr_sset, wr_sclr, wr_pset, wr_pclr, wr_ctrl;
  assign wr_ack  = wr_en && (grp == GRP_ACK);
  assign wr_mset = wr_en && (grp == GRP_MSET);
  assign wr_mclr = wr_en && (grp == GRP_MCLR);
  assign wr_sset = wr_en && (grp == GRP_SSET);
  assign wr_sclr = wr_en && (grp == GRP_SCLR);
  assign wr_pset = wr_en && (grp == GRP_PSET);
  assign wr_pclr = wr_en && (grp == GRP_PCLR);
  assign wr_ctrl = wr_en && (grp == GRP_CTRL) && (word == '0);

  logic [NUM_LINES-1:0] mask_q, mask_d, sense_q, sense_d, pol_q, pol_d;
  logic [NUM_LINES-1:0] status_q, status_d, record;
  logic                 en_q, en_d, eo_q, eo_d;
  logic [DATA_W-1:0]    rdata_q, rdata_d;

  function automatic logic [DATA_W-1:0] pick(input logic [NUM_LINES-1:0] v,
                                             input logic [WORD_W-1:0] w);
    logic [PADW-1:0] p;
    int              idx;
    p = '0;
    p[NUM_LINES-1:0] = v;
    idx = (int'(w) < NWORDS) ? int'(w) : 0;
    return (int'(w) < NWORDS) ? p[idx*DATA_W +: DATA_W] : '0;
  endfunction

  always_comb begin
    mask_d = mask_q;
    if (wr_mset) mask_d = mask_q | wbit;
    if (wr_mclr) mask_d = mask_q & ~wbit;

    sense_d = sense_q;
    if (wr_sset) sense_d = sense_q | wbit;
    if (wr_sclr) sense_d = sense_q & ~wbit;

    pol_d = pol_q;
    if (wr_pset) pol_d = pol_q | wbit;
    if (wr_pclr) pol_d = pol_q & ~wbit;

    en_d = en_q;
    eo_d = eo_q;
    if (wr_ctrl) begin
      en_d = wdata[CTRL_EN];
      eo_d = wdata[CTRL_EDGE_ONLY];
    end

    record   = event_vec & ~(sense_q & {NUM_LINES{eo_q}});
    status_d = (status_q & ~(wr_ack ? wbit : '0) & ~replay_clr) | record;

    rdata_d = rdata_q;
    if (rd_en) begin
      case (grp)
        GRP_STATUS:         rdata_d = pick(status_q, word);
        GRP_MSET, GRP_MCLR: rdata_d = pick(mask_q, word);
        GRP_SSET, GRP_SCLR: rdata_d = pick(sense_q, word);
        GRP_PSET, GRP_PCLR: rdata_d = pick(pol_q, word);
        GRP_CTRL:           rdata_d = (word == '0) ?
                                      {{(DATA_W-3){1'b0}}, busy, eo_q, en_q} : '0;
        default:            rdata_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q   <= '0;
      sense_q  <= '0;
      pol_q    <= '1;
      status_q <= '0;
      en_q     <= 1'b0;
      eo_q     <= 1'b0;
      rdata_q  <= '0;
    end else begin
      mask_q   <= mask_d;
      sense_q  <= sense_d;
      pol_q    <= pol_d;
      status_q <= status_d;
      en_q     <= en_d;
      eo_q     <= eo_d;
      rdata_q  <= rdata_d;
    end
  end

  assign flush_start_o = wr_ctrl && wdata[CTRL_FLUSH] && wdata[CTRL_EN] && !busy;
  assign mask_o   = mask_q;
  assign sense_o  = sense_q;
  assign pol_o    = pol_q;
  assign status_o = status_q;
  assign rdata    = rdata_q;

  // R8: edge-only mode lets no level line gain a status bit
  assert_edge_only_blocks_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
    eo_q |=> ((status_q & ~$past(status_q) & $past(sense_q)) == '0));

  // R7: acknowledged bits with no coincident event are cleared
  assert_ack_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ack |=> ((status_q & $past(wbit & ~event_vec)) == '0));

endmodule

// File: rtl/sic_replay.sv
module sic_replay #(
  parameter int NUM_LINES = 40
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 flush_start,
  input  logic [NUM_LINES-1:0] status,
  input  logic [NUM_LINES-1:0] mask,
  input  logic [NUM_LINES-1:0] pol,
  output logic                 busy_o,
  output logic [NUM_LINES-1:0] clr_o,
  output logic [NUM_LINES-1:0] replay_o
);

  localparam int CNT_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(NUM_LINES - 1);

  logic [CNT_W-1:0]     idx_q, idx_d;
  logic                 busy_q, busy_d;
  logic [NUM_LINES-1:0] pulse_q, pulse_d;
  logic                 sel;

  always_comb begin
    sel     = busy_q && status[idx_q] && !mask[idx_q];
    clr_o   = sel ? ({{(NUM_LINES-1){1'b0}}, 1'b1} << idx_q) : '0;
    pulse_d = clr_o;
    busy_d  = busy_q;
    idx_d   = idx_q;
    if (flush_start) begin
      busy_d = 1'b1;
      idx_d  = '0;
    end else if (busy_q) begin
      if (idx_q == LAST) begin
        busy_d = 1'b0;
        idx_d  = '0;
      end else begin
        idx_d = idx_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q   <= '0;
      busy_q  <= 1'b0;
      pulse_q <= '0;
    end else begin
      idx_q   <= idx_d;
      busy_q  <= busy_d;
      pulse_q <= pulse_d;
    end
  end

  // resting level is the inverse polarity; a pulse drives the polarity value
  assign replay_o = ~(pulse_q ^ pol);
  assign busy_o   = busy_q;

  assert_one_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pulse_q));

  assert_pulse_needs_scan_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_q != '0) |-> $past(busy_q));

  assert_scan_index_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    int'(idx_q) < NUM_LINES);

  assert_masked_not_replayed_R11: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pulse_q & $past(mask)) == '0));

endmodule

// File: rtl/sleep_irq_capture.sv
module sleep_irq_capture
  import sic_pkg::*;
#(
  parameter int NUM_LINES = 40,
  parameter int ADDR_W    = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_wr_en,
  input  logic                 bus_rd_en,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [DATA_W-1:0]    bus_wdata,
  output logic [DATA_W-1:0]    bus_rdata,
  input  logic [NUM_LINES-1:0] irq_in,
  output logic [NUM_LINES-1:0] replay_out
);

  // asynchronous assert, synchronous release
  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  logic [NUM_LINES-1:0] event_vec, replay_clr, mask, sense, pol, status;
  logic                 busy, flush_start;

  for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
    sic_line_detect u_det (
      .clk     (clk),
      .rst_n   (rst_sync_q),
      .irq_raw (irq_in[n]),
      .pol     (pol[n]),
      .level   (sense[n]),
      .event_o (event_vec[n])
    );
  end

  sic_regs #(.NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W)) u_regs (
    .clk           (clk),
    .rst_n         (rst_sync_q),
    .wr_en         (bus_wr_en),
    .rd_en         (bus_rd_en),
    .addr          (bus_addr),
    .wdata         (bus_wdata),
    .rdata         (bus_rdata),
    .event_vec     (event_vec),
    .replay_clr    (replay_clr),
    .busy          (busy),
    .mask_o        (mask),
    .sense_o       (sense),
    .pol_o         (pol),
    .status_o      (status),
    .flush_start_o (flush_start)
  );

  sic_replay #(.NUM_LINES(NUM_LINES)) u_replay (
    .clk         (clk),
    .rst_n       (rst_sync_q),
    .flush_start (flush_start),
    .status      (status),
    .mask        (mask),
    .pol         (pol),
    .busy_o      (busy),
    .clr_o       (replay_clr),
    .replay_o    (replay_out)
  );

endmodule

// File: tb/sleep_irq_capture_bench.sv
`timescale 1ns/1ps
module sleep_irq_capture_bench;

  localparam int N = 40;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_wr_en = 1'b0;
  logic          bus_rd_en = 1'b0;
  logic [11:0]   bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [N-1:0]  irq_in = '0;
  logic [N-1:0]  replay_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  sleep_irq_capture u_sleep_irq_capture (
    .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_in(irq_in), .replay_out(replay_out)
  );

  // scoreboard of expected read data
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_seen = 1'b0;

  always @(posedge clk) rd_seen <= bus_rd_en;

  always @(negedge clk) begin
    if (rd_seen && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (bus_rdata !== e) begin
        errors++;
        $display("FAIL %s: rdata=%h expected=%h", t, bus_rdata, e);
      end
    end
  end

  task automatic chk(input bit ok, input string t, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", t, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr_en = 1'b1;
    @(negedge clk);
    bus_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] e, input string t);
    bus_addr = a; bus_rd_en = 1'b1;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    bus_rd_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] exp_v;
    int pulses;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(5);

    // R1 reset state
    chk(replay_out == '0, "R1 replay idle", 64'(replay_out), 64'h0);
    rd(12'h000, 32'h0, "R1 status w0");
    rd(12'h0C0, 32'h0, "R1 mask w0");
    rd(12'h180, 32'h0, "R1 sense w0");
    rd(12'h240, 32'hFFFF_FFFF, "R1 polarity w0");
    rd(12'h244, 32'h0000_00FF, "R2 R1 polarity w1 (lines 32..39)");
    rd(12'h300, 32'h0, "R1 control");

    // R3 set/clear pairs
    wr(12'h0C0, 32'h5);
    rd(12'h0C0, 32'h5, "R3 mask set");
    wr(12'h0C0, 32'h0);
    rd(12'h0C0, 32'h5, "R3 zero bits no effect");
    wr(12'h100, 32'h1);
    rd(12'h100, 32'h4, "R3 mask clear, read at clear address");
    wr(12'h100, 32'h4);
    rd(12'h0C0, 32'h0, "R3 mask cleared");

    // R4 rising edge, R6 recorded while disabled
    irq_in[3] = 1'b1; idle(4);
    rd(12'h000, 32'h8, "R4 R6 rising edge recorded while disabled");
    wr(12'h040, 32'h8);
    rd(12'h000, 32'h0, "R7 ack clears");
    irq_in[3] = 1'b0; idle(4);
    rd(12'h000, 32'h0, "R4 falling edge ignored for rising line");

    // R4 falling polarity
    wr(12'h280, 32'h20);
    rd(12'h240, 32'hFFFF_FFDF, "R3 polarity clear");
    irq_in[5] = 1'b1; idle(4);
    rd(12'h000, 32'h0, "R4 rising edge ignored for falling line");
    irq_in[5] = 1'b0; idle(4);
    rd(12'h000, 32'h20, "R4 falling edge recorded");
    wr(12'h040, 32'h20);
    rd(12'h000, 32'h0, "R7 ack clears line 5");

    // R5 level on line 33 (word 1 bit 1)
    wr(12'h184, 32'h2);
    rd(12'h1C4, 32'h2, "R2 R3 sense w1 readback");
    irq_in[33] = 1'b1; idle(4);
    rd(12'h004, 32'h2, "R5 level recorded");
    wr(12'h044, 32'h2);
    rd(12'h004, 32'h2, "R5 ack does not stick while active");
    irq_in[33] = 1'b0; idle(4);
    wr(12'h044, 32'h2);
    rd(12'h004, 32'h0, "R5 ack sticks after release");

    // R8 edge-only mode
    wr(12'h300, 32'h2);
    irq_in[33] = 1'b1; irq_in[3] = 1'b1; idle(4);
    rd(12'h004, 32'h0, "R8 level line suppressed");
    rd(12'h000, 32'h8, "R8 edge line still recorded");
    rd(12'h300, 32'h2, "R13 control readback");
    irq_in[33] = 1'b0; idle(4);
    wr(12'h300, 32'h0);

    // R10 flush without enable
    wr(12'h300, 32'h4);
    pulses = 0;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (replay_out != N'(40'h20)) pulses++;
    end
    chk(pulses == 0, "R10 no pulse when disabled", 64'(pulses), 64'h0);
    rd(12'h000, 32'h8, "R10 status kept");
    rd(12'h300, 32'h0, "R10 control reads 0");

    // set up lines 3, 5, 10 (masked), 33 for a flush
    irq_in[5] = 1'b1; idle(3);
    irq_in[5] = 1'b0;
    irq_in[10] = 1'b1;
    wr(12'h1C4, 32'h2);
    irq_in[33] = 1'b1; idle(5);
    wr(12'h0C0, 32'h400);
    rd(12'h000, 32'h428, "R11 status before flush");
    rd(12'h004, 32'h2, "R2 status w1 before flush");

    // R9 R12 flush scan timing and polarity
    wr(12'h300, 32'h5);
    for (int i = 0; i < N; i++) begin
      @(negedge clk);
      exp_v = N'(40'h20);
      if (i == 3 || i == 33) exp_v[i] = 1'b1;
      if (i == 5) exp_v[5] = 1'b0;
      chk(replay_out == exp_v, $sformatf("R9 R12 replay cycle %0d", i),
          64'(replay_out), 64'(exp_v));
    end
    idle(2);
    rd(12'h000, 32'h400, "R11 masked status survives flush");
    rd(12'h004, 32'h0, "R9 replayed status cleared");
    rd(12'h300, 32'h1, "R13 flush bit reads 0 after scan");

    // R13 busy readback, R11 replay once unmasked
    wr(12'h100, 32'h400);
    wr(12'h300, 32'h5);
    rd(12'h300, 32'h5, "R13 flush bit reads 1 during scan");
    wr(12'h300, 32'h5);
    pulses = 0;
    for (int i = 0; i < 45; i++) begin
      @(negedge clk);
      if (replay_out[10]) pulses++;
    end
    chk(pulses == 1, "R11 R13 unmasked line replayed once", 64'(pulses), 64'h1);
    rd(12'h000, 32'h0, "R11 status cleared after replay");
    rd(12'h300, 32'h1, "R13 scan finished");

    idle(3);
    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule